// File: doc/BRIEF.md
# BCD Calendar with Snapshot Registers

This block keeps time of day and calendar in packed BCD: seconds, minutes, hours in 24-hour form, day of week, date, month, two-digit year and a century flag. A one-cycle `tick_i` pulse, once per second, advances the live counters. The host never sees those counters directly. It reads and writes eight byte-wide holding registers that sit in the top eight locations of an 8K-byte address space and are reached over a simple synchronous bus.

In the cycle after each counting tick, all seven time registers are refreshed together from the live counters. A control byte at the lowest of the eight addresses has two bits. The snapshot bit stops the refresh so that the host can read a consistent time. The set bit also stops the refresh, and when it is cleared, the seven holding registers are copied into the live counters in one step. The halt bit in the seconds register and the century-enable bit in the day register act on the live counters as soon as they are written.

Top module: `bcd_calendar_shadow`

## Requirements
- R1: After reset, reads return 8'h00 from control (offset 0), 8'h80 from seconds (offset 1, halt bit set), 8'h00 from minutes (2) and hours (3), 8'h01 from day (4), date (5) and month (6), and 8'h00 from year (7). Offsets are address minus 13'h1FF8.
- R2: Each counting tick advances seconds 00–59 (bits 6:0), then minutes 00–59 (bits 6:0), then hours 00–23 (bits 5:0), with a carry at each wrap.
- R3: On an hour wrap, day of week (day bits 2:0) goes from 7 to 1 and otherwise increments. Date (bits 5:0) wraps to 01 after the last day of the month: 30 for months 04, 06, 09 and 11, 31 for the other months, and for month 02 it is 29 when the year is divisible by four and 28 otherwise.
- R4: Month (bits 4:0) wraps from 12 to 01 and carries into year (bits 7:0), which wraps from 99 to 00. On that year wrap, the century bit (day bit 4) toggles only while century-enable (day bit 5) is 1.
- R5: The holding registers change in the second clock after the tick edge, all seven at once. A read returns the data of the cycle it was issued, on `rdata_o` one cycle later.
- R6: While control bit 6 is 1, the holding registers keep their values and the live counters keep counting. After the bit is cleared, the next tick shows the advanced count.
- R7: Control bit 7 also stops the refresh. Writing control with bit 7 cleared while it is set loads all seven holding registers into the live counters.
- R8: Seconds bit 7 = 1 halts counting and refresh as soon as it is written. Writing it as 0 restarts counting from the unchanged live seconds value.
- R9: Writing the day register takes effect on century-enable at once, with no set bit needed.
- R10: Bits fixed at zero read 0: minutes bit 7, hours bits 7:6, day bits 7:6 and 3, date bits 7:6, month bits 7:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle once-per-second advance strobe |
| cs_i | input | 1 | Bus select |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 13 | Byte address; the top eight locations respond |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data; 0 when no register is read |

## Verification
The hardest situations to reach from the ports are the multi-level carries (end of month, leap February, end of year with the century flag), because counting there one tick at a time would take far too long. The bench uses the set bit to load a time one second before each boundary, releases the bit, gives one or two ticks and reads back all seven registers. The copy timing is checked by keeping a read of seconds running across the tick, so that the cycle in which the new value first appears is observed directly. Freeze and halt are checked by giving ticks while frozen or halted and then showing that the live count did, or did not, move on.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;

  localparam int unsigned NUM_REGS = 8;
  localparam int unsigned REG_AW   = $clog2(NUM_REGS);

  typedef enum logic [REG_AW-1:0] {
    REG_CTRL = 3'd0,
    REG_SEC  = 3'd1,
    REG_MIN  = 3'd2,
    REG_HOUR = 3'd3,
    REG_DAY  = 3'd4,
    REG_DATE = 3'd5,
    REG_MON  = 3'd6,
    REG_YEAR = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [5:0] hour;
    logic [2:0] dow;
    logic [5:0] date;
    logic [4:0] mon;
    logic [7:0] year;
    logic       cent;
  } rtc_time_t;

  typedef logic [NUM_REGS-1:0][7:0] rtc_bank_t;

  localparam rtc_time_t RESET_TIME = '{sec: 7'h00, min: 7'h00, hour: 6'h00, dow: 3'd1,
                                       date: 6'h01, mon: 5'h01, year: 8'h00, cent: 1'b0};

  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    return (v[3:0] == 4'h9) ? {v[7:4] + 4'h1, 4'h0} : v + 8'h01;
  endfunction

  function automatic logic is_leap(input logic [7:0] year);
    if (year[4]) return (year[3:0] == 4'h2) || (year[3:0] == 4'h6);
    return (year[3:0] == 4'h0) || (year[3:0] == 4'h4) || (year[3:0] == 4'h8);
  endfunction

  function automatic logic [5:0] last_date(input logic [4:0] mon, input logic [7:0] year);
    case (mon)
      5'h02:                      return is_leap(year) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default:                    return 6'h31;
    endcase
  endfunction

  function automatic logic [7:0] reg_mask(input int unsigned idx);
    case (idx)
      1:       return 8'hFF;
      2:       return 8'h7F;
      3:       return 8'h3F;
      4:       return 8'h37;
      5:       return 8'h3F;
      6:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  // byte view of a time value; control byte supplied by caller
  function automatic rtc_bank_t pack_bank(input rtc_time_t t, input logic stop,
                                          input logic cen, input logic [7:0] ctrl);
    rtc_bank_t b;
    b[REG_CTRL] = ctrl;
    b[REG_SEC]  = {stop, t.sec};
    b[REG_MIN]  = {1'b0, t.min};
    b[REG_HOUR] = {2'b00, t.hour};
    b[REG_DAY]  = {2'b00, cen, t.cent, 1'b0, t.dow};
    b[REG_DATE] = {2'b00, t.date};
    b[REG_MON]  = {3'b000, t.mon};
    b[REG_YEAR] = t.year;
    return b;
  endfunction

endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_shadow_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      load_i,
  input  rtc_time_t load_val_i,
  input  logic      stop_wr_i,
  input  logic      stop_val_i,
  input  logic      cen_wr_i,
  input  logic      cen_val_i,
  output rtc_time_t now_o,
  output logic      stop_o,
  output logic      cen_o,
  output logic      adv_o
);

  rtc_time_t now_q, nxt;
  logic      stop_q, cen_q, adv_q;
  logic      w_sec, w_min, w_hour, day_roll, mon_roll, yr_roll;
  logic      step;

  assign step = tick_i && !stop_q && !load_i;

  always_comb begin
    nxt      = now_q;
    w_sec    = now_q.sec  == 7'h59;
    w_min    = now_q.min  == 7'h59;
    w_hour   = now_q.hour == 6'h23;
    day_roll = w_sec && w_min && w_hour;
    mon_roll = day_roll && (now_q.date == last_date(now_q.mon, now_q.year));
    yr_roll  = mon_roll && (now_q.mon == 5'h12);

    nxt.sec = w_sec ? 7'h00 : 7'(bcd_next({1'b0, now_q.sec}));
    if (w_sec)
      nxt.min = w_min ? 7'h00 : 7'(bcd_next({1'b0, now_q.min}));
    if (w_sec && w_min)
      nxt.hour = w_hour ? 6'h00 : 6'(bcd_next({2'b00, now_q.hour}));
    if (day_roll) begin
      nxt.dow  = (now_q.dow == 3'd7) ? 3'd1 : now_q.dow + 3'd1;
      nxt.date = mon_roll ? 6'h01 : 6'(bcd_next({2'b00, now_q.date}));
    end
    if (mon_roll)
      nxt.mon = (now_q.mon == 5'h12) ? 5'h01 : 5'(bcd_next({3'b000, now_q.mon}));
    if (yr_roll) begin
      nxt.year = (now_q.year == 8'h99) ? 8'h00 : bcd_next(now_q.year);
      if (now_q.year == 8'h99 && cen_q) nxt.cent = !now_q.cent;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      now_q  <= RESET_TIME;
      stop_q <= 1'b1;
      cen_q  <= 1'b0;
      adv_q  <= 1'b0;
    end else begin
      if (load_i)    now_q <= load_val_i;
      else if (step) now_q <= nxt;
      if (stop_wr_i) stop_q <= stop_val_i;
      if (cen_wr_i)  cen_q  <= cen_val_i;
      adv_q <= step;
    end
  end

  assign now_o  = now_q;
  assign stop_o = stop_q;
  assign cen_o  = cen_q;
  assign adv_o  = adv_q;

endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
  import rtc_shadow_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] sel_i,
  input  logic [7:0]        wdata_i,
  input  logic              copy_req_i,
  input  rtc_time_t         live_i,
  input  logic              stop_i,
  input  logic              cen_i,
  output rtc_bank_t         bank_o,
  output rtc_time_t         hold_o,
  output logic              freeze_o,
  output logic              copy_o,
  output logic              load_o
);

  localparam rtc_bank_t RESET_BANK = pack_bank(RESET_TIME, 1'b1, 1'b0, 8'h00);

  rtc_bank_t hold_q, live_bank;

  assign live_bank = pack_bank(live_i, stop_i, cen_i, hold_q[REG_CTRL]);
  assign freeze_o  = hold_q[REG_CTRL][7] | hold_q[REG_CTRL][6];
  assign copy_o    = copy_req_i && !freeze_o;
  assign load_o    = wr_en_i && (sel_i == REG_CTRL) && hold_q[REG_CTRL][7] && !wdata_i[7];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   hold_q[i] <= RESET_BANK[i];
      else if (wr_en_i && sel_i == REG_AW'(i))       hold_q[i] <= wdata_i & reg_mask(i);
      else if (copy_o)                               hold_q[i] <= live_bank[i];
    end
  end

  assign hold_o = '{sec:  hold_q[REG_SEC][6:0],  min:  hold_q[REG_MIN][6:0],
                    hour: hold_q[REG_HOUR][5:0], dow:  hold_q[REG_DAY][2:0],
                    date: hold_q[REG_DATE][5:0], mon:  hold_q[REG_MON][4:0],
                    year: hold_q[REG_YEAR],      cent: hold_q[REG_DAY][4]};
  assign bank_o = hold_q;

endmodule

// File: rtl/bcd_calendar_shadow.sv
module bcd_calendar_shadow
  import rtc_shadow_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);

  localparam int unsigned HI_W = ADDR_W - REG_AW;

  logic              in_win, wr_en, rd_en;
  logic [REG_AW-1:0] sel;
  rtc_time_t         live_time, hold_time;
  rtc_bank_t         bank;
  logic              stop, cen, adv, copy, load, freeze;
  logic              stop_wr, stop_val, cen_wr, cen_val;
  logic [7:0]        rdata_q;

  assign in_win = &addr_i[ADDR_W-1:REG_AW];
  assign sel    = addr_i[REG_AW-1:0];
  assign wr_en  = cs_i && we_i && in_win;
  assign rd_en  = cs_i && !we_i && in_win;

  // halt and century-enable act on the live side at once
  assign stop_wr  = (wr_en && sel == REG_SEC) || load;
  assign stop_val = load ? bank[REG_SEC][7] : wdata_i[7];
  assign cen_wr   = (wr_en && sel == REG_DAY) || load;
  assign cen_val  = load ? bank[REG_DAY][5] : wdata_i[5];

  rtc_time_core i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .load_i     (load),
    .load_val_i (hold_time),
    .stop_wr_i  (stop_wr),
    .stop_val_i (stop_val),
    .cen_wr_i   (cen_wr),
    .cen_val_i  (cen_val),
    .now_o      (live_time),
    .stop_o     (stop),
    .cen_o      (cen),
    .adv_o      (adv)
  );

  rtc_shadow_regs i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .sel_i      (sel),
    .wdata_i    (wdata_i),
    .copy_req_i (adv),
    .live_i     (live_time),
    .stop_i     (stop),
    .cen_i      (cen),
    .bank_o     (bank),
    .hold_o     (hold_time),
    .freeze_o   (freeze),
    .copy_o     (copy),
    .load_o     (load)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_q <= '0;
    else if (rd_en) rdata_q <= bank[sel];
    else            rdata_q <= '0;
  end

  assign rdata_o = rdata_q;

  logic unused_hi;
  assign unused_hi = ^{HI_W{1'b0}};

endmodule

// File: rtl/rtc_shadow_chk.sv
module rtc_shadow_chk
  import rtc_shadow_pkg::*;
#(
  parameter int unsigned ADDR_W = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              cs_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        rdata_o,
  input logic              copy,
  input logic              load,
  input logic              freeze,
  input logic              stop,
  input logic              cen,
  input rtc_time_t         live_time,
  input rtc_time_t         hold_time
);

  logic rd_min, rd_hour;
  assign rd_min  = cs_i && !we_i && (addr_i == ADDR_W'({ADDR_W{1'b1}} - 5));
  assign rd_hour = cs_i && !we_i && (addr_i == ADDR_W'({ADDR_W{1'b1}} - 4));

  AST_COPY_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    copy |-> $past(tick_i)) else $error("copy without preceding tick"); // R5

  AST_FREEZE_NO_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze |-> !copy) else $error("copy while frozen"); // R6

  AST_FREEZE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze && !(cs_i && we_i)) |=> $stable(hold_time)) else $error("bank moved while frozen"); // R6

  AST_LOAD_TRANSFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load |=> (live_time == $past(hold_time))) else $error("release did not load counters"); // R7

  AST_STOP_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop && !load) |=> $stable(live_time)) else $error("counters moved while halted"); // R8

  AST_CENT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load && !cen) |=> $stable(live_time.cent)) else $error("century toggled while disabled"); // R4

  AST_ZERO_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_min |=> (rdata_o[7] == 1'b0)) else $error("minutes bit 7 set"); // R10

  AST_ZERO_HOUR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hour |=> (rdata_o[7:6] == 2'b00)) else $error("hours bits 7:6 set"); // R10

endmodule

bind bcd_calendar_shadow rtc_shadow_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .cs_i      (cs_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .copy      (copy),
  .load      (load),
  .freeze    (freeze),
  .stop      (stop),
  .cen       (cen),
  .live_time (live_time),
  .hold_time (hold_time)
);

// File: tb/test_bcd_calendar_shadow.sv
`timescale 1ns/1ps
module test_bcd_calendar_shadow;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        cs = 1'b0;
  logic        we = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;

  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  bcd_calendar_shadow #(.ADDR_W(13)) i_bcd_calendar_shadow (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cs_i(cs), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata)
  );

  localparam logic [12:0] BASE = 13'h1FF8;

  // {in sec..year, ticks, expected sec..year}
  localparam int NVEC = 11;
  localparam logic [14:0][7:0] VEC_TAB [NVEC] = '{
    {8'h59,8'h59,8'h23,8'h27,8'h31,8'h12,8'h99, 8'd1, 8'h00,8'h00,8'h00,8'h31,8'h01,8'h01,8'h00},
    {8'h59,8'h59,8'h23,8'h03,8'h28,8'h02,8'h23, 8'd1, 8'h00,8'h00,8'h00,8'h04,8'h01,8'h03,8'h23},
    {8'h59,8'h59,8'h23,8'h05,8'h28,8'h02,8'h24, 8'd1, 8'h00,8'h00,8'h00,8'h06,8'h29,8'h02,8'h24},
    {8'h59,8'h59,8'h23,8'h06,8'h29,8'h02,8'h24, 8'd1, 8'h00,8'h00,8'h00,8'h07,8'h01,8'h03,8'h24},
    {8'h59,8'h59,8'h23,8'h07,8'h30,8'h04,8'h10, 8'd1, 8'h00,8'h00,8'h00,8'h01,8'h01,8'h05,8'h10},
    {8'h56,8'h34,8'h12,8'h02,8'h15,8'h06,8'h42, 8'd2, 8'h58,8'h34,8'h12,8'h02,8'h15,8'h06,8'h42},
    {8'h59,8'h59,8'h09,8'h02,8'h15,8'h06,8'h42, 8'd1, 8'h00,8'h00,8'h10,8'h02,8'h15,8'h06,8'h42},
    {8'h59,8'h59,8'h23,8'h17,8'h31,8'h12,8'h99, 8'd1, 8'h00,8'h00,8'h00,8'h11,8'h01,8'h01,8'h00},
    {8'h59,8'h59,8'h23,8'h01,8'h30,8'h09,8'h01, 8'd1, 8'h00,8'h00,8'h00,8'h02,8'h01,8'h10,8'h01},
    {8'h59,8'h59,8'h23,8'h01,8'h28,8'h02,8'h96, 8'd1, 8'h00,8'h00,8'h00,8'h02,8'h29,8'h02,8'h96},
    {8'h59,8'h59,8'h23,8'h03,8'h31,8'h01,8'h05, 8'd1, 8'h00,8'h00,8'h00,8'h04,8'h01,8'h02,8'h05}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input int idx, input logic [7:0] d);
    cs = 1'b1; we = 1'b1; addr = BASE + 13'(idx); wdata = d;
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input int idx, output logic [7:0] d);
    cs = 1'b1; we = 1'b0; addr = BASE + 13'(idx);
    @(negedge clk);
    d = rdata;
    cs = 1'b0;
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_time(input logic [6:0][7:0] t);
    bus_write(0, 8'h80);
    for (int k = 1; k <= 7; k++) bus_write(k, t[7-k]);
    bus_write(0, 8'h00);
  endtask

  function automatic string tag_of(input int k);
    if (k <= 3) return "R2";
    if (k <= 5) return "R3";
    return "R4";
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] d, b, c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset view
    bus_read(0, d); check("R1 ctrl", d, 8'h00);
    bus_read(1, d); check("R1 sec", d, 8'h80);
    bus_read(2, d); check("R1 min", d, 8'h00);
    bus_read(3, d); check("R1 hour", d, 8'h00);
    bus_read(4, d); check("R1 day", d, 8'h01);
    bus_read(5, d); check("R1 date", d, 8'h01);
    bus_read(6, d); check("R1 month", d, 8'h01);
    bus_read(7, d); check("R1 year", d, 8'h00);

    // table walk: load, tick, read back (R2 R3 R4 R7)
    for (int v = 0; v < NVEC; v++) begin
      logic [6:0][7:0] tin;
      for (int k = 1; k <= 7; k++) tin[7-k] = VEC_TAB[v][15-k];
      set_time(tin);
      for (int t = 0; t < int'(VEC_TAB[v][7]); t++) pulse_tick();
      for (int k = 1; k <= 7; k++) begin
        bus_read(k, d);
        check(tag_of(k), d, VEC_TAB[v][7-k]);
      end
    end

    // R5 copy lands in the second cycle after the tick edge
    set_time({8'h20, 8'h00, 8'h10, 8'h01, 8'h01, 8'h01, 8'h30});
    tick = 1'b1; cs = 1'b1; we = 1'b0; addr = BASE + 13'd1;
    @(negedge clk); tick = 1'b0;
    @(negedge clk); b = rdata;
    @(negedge clk); c = rdata;
    cs = 1'b0;
    @(negedge clk);
    check("R5 before copy", b, 8'h20);
    check("R5 after copy", c, 8'h21);

    // R6 snapshot freeze, counters keep running
    bus_write(0, 8'h40);
    repeat (3) pulse_tick();
    bus_read(1, d); check("R6 frozen", d, 8'h21);
    bus_write(0, 8'h00);
    bus_read(1, d); check("R6 held until tick", d, 8'h21);
    pulse_tick();
    bus_read(1, d); check("R6 resumed", d, 8'h25);

    // R7 set bit freezes, release loads counters
    bus_write(0, 8'h80);
    pulse_tick();
    bus_read(1, d); check("R7 frozen by set bit", d, 8'h25);
    bus_write(1, 8'h40);
    bus_write(0, 8'h00);
    pulse_tick();
    bus_read(1, d); check("R7 loaded value counts", d, 8'h41);

    // R8 halt bit
    bus_write(1, 8'h90);
    repeat (3) pulse_tick();
    bus_read(1, d); check("R8 halted", d, 8'h90);
    bus_write(1, 8'h10);
    pulse_tick();
    bus_read(1, d); check("R8 restart from live count", d, 8'h42);

    // R9 century enable without set bit
    set_time({8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99});
    bus_write(4, 8'h27);
    pulse_tick();
    bus_read(4, d); check("R9 century toggled", d, 8'h31);
    bus_read(7, d); check("R4 year wrap", d, 8'h00);

    // R10 fixed-zero bits
    bus_write(0, 8'h80);
    for (int k = 2; k <= 6; k++) bus_write(k, 8'hFF);
    bus_read(2, d); check("R10 min", d, 8'h7F);
    bus_read(3, d); check("R10 hour", d, 8'h3F);
    bus_read(4, d); check("R10 day", d, 8'h37);
    bus_read(5, d); check("R10 date", d, 8'h3F);
    bus_read(6, d); check("R10 month", d, 8'h1F);

    summary();
  end

endmodule